// File: doc/BRIEF.md
# Per-Channel Trigger Qualifier

This block sits between a synchronized, polarity-corrected trigger level and a channel's sample path. It decides, cycle by cycle, whether samples may move. One instance serves one channel.

In level mode the enable tracks the trigger with one clock of latency. In edge mode a rising trigger opens a window that closes after a programmed number of sample strobes. A programmed count of zero leaves the window open with no limit. Each accepted edge also starts a backoff timer, counted in system clocks. Until that timer runs out, further rising edges are ignored, which suppresses ringing or bounce on the trigger line. An edge accepted while a finite window is still open restarts the count. Changing the mode discards any open window and any running backoff.

Top module: `trig_qualifier`

## Requirements
- R1: While reset is held, en_o is 0. Reset leaves the mode at level, the window closed and the backoff expired, so a trigger that is high at the first clock edge after release sets en_o after that edge, with mode_i = 0.
- R2: With mode_i = 0 (level), en_o after each clock edge equals the value trig_i had at that edge. smp_stb_i and smp_cnt_i have no effect.
- R3: With mode_i = 1 (edge), a rising edge is trig_i = 1 at a clock edge after trig_i = 0 at the previous one. A rising edge that is accepted sets en_o after that clock edge. Once the window is open, trig_i staying high or falling does not close it.
- R4: When the count latched at acceptance is N > 0, the window counts the strobes seen at the clock edges after the accepting one. en_o falls after the edge that carries the N-th strobe. A strobe at the accepting edge is not counted.
- R5: When the count latched at acceptance is 0, en_o stays high for any number of strobes until the mode changes.
- R6: After a rising edge is accepted with a backoff of B, rising edges at the B clock edges that follow are ignored. A rising edge B+1 or more edges later is accepted. With B = 0 the very next edge may be accepted.
- R7: A rising edge accepted while a finite window is open reloads the window from the current smp_cnt_i.
- R8: smp_cnt_i and backoff_i are captured only when a rising edge is accepted. Changing them while a window or a backoff is running has no effect.
- R9: A clock edge where mode_i differs from the mode in force closes the window and clears the backoff. A rising edge at that same clock edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Synchronized trigger level, active high |
| smp_stb_i | input | 1 | One-cycle strobe per sample at the channel's user rate |
| mode_i | input | 1 | 0 = level, 1 = edge |
| smp_cnt_i | input | CNT_W (64) | Window length in samples, 0 = unlimited |
| backoff_i | input | BO_W (31) | Edge-ignore time in clock cycles after an accepted edge |
| en_o | output | 1 | Sample-path enable |

## Verification
A wrong remaining-sample count shows on the port as a window that is too short or too long, by a whole number of strobe periods. It surfaces at the clock edge after the strobe where the window should have closed. A stale backoff value shows up as a rising edge that is ignored or honoured by mistake, so en_o is wrong one clock after that edge. A window that survives a mode change does not show at once in level mode. It does show as a spurious high enable the first clock after edge mode returns. The bench sweeps window lengths against strobe spacings and backoff values against edge distances, and uses exactly that return to edge mode to expose leftover state.

// File: rtl/trig_qual_pkg.sv
package trig_qual_pkg;
  typedef enum logic {
    TQ_LEVEL = 1'b0,
    TQ_EDGE  = 1'b1
  } tq_mode_e;
endpackage

// File: rtl/tq_edge_det.sv
module tq_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_q_o,
  output logic rise_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q_o <= 1'b0;
    else         lvl_q_o <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q_o;

  // R3: a detected rise leaves the stored level high
  a_r3_rise_registers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> lvl_q_o);
endmodule

// File: rtl/tq_backoff.sv
module tq_backoff #(
  parameter int BO_W = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [BO_W-1:0] val_i,
  output logic            busy_o
);
  logic [BO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - BO_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  a_r6_load_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (busy_o == ($past(val_i) != '0)));

  a_r9_clear_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o);
endmodule

// File: rtl/tq_window.sv
module tq_window #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             stb_i,
  output logic             open_o
);
  logic             open_q;
  logic             inf_q;
  logic [CNT_W-1:0] rem_q;
  logic             last_stb;

  assign last_stb = open_q && !inf_q && stb_i && (rem_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      inf_q  <= 1'b0;
      rem_q  <= '0;
    end else if (clr_i) begin
      open_q <= 1'b0;
      inf_q  <= 1'b0;
      rem_q  <= '0;
    end else if (load_i) begin
      // restart takes priority over a strobe in the same cycle
      open_q <= 1'b1;
      inf_q  <= (len_i == '0);
      rem_q  <= len_i;
    end else if (open_q && !inf_q && stb_i) begin
      rem_q <= rem_q - CNT_W'(1);
      if (last_stb) open_q <= 1'b0;
    end
  end

  assign open_o = open_q;

  a_r4_finite_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !inf_q) |-> (rem_q != '0));

  a_r4_close_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_stb && !load_i && !clr_i) |=> !open_q);

  a_r5_unlimited_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && inf_q && !clr_i) |=> open_q);

  a_r4_no_strobe_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !stb_i && !load_i && !clr_i) |=> (open_q && $stable(rem_q)));
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
  import trig_qual_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int BO_W  = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             smp_stb_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] smp_cnt_i,
  input  logic [BO_W-1:0]  backoff_i,
  output logic             en_o
);
  tq_mode_e mode_q;
  tq_mode_e mode_n;
  logic     mode_chg;
  logic     trig_q;
  logic     rise;
  logic     bo_busy;
  logic     accept;
  logic     win_open;

  assign mode_n   = tq_mode_e'(mode_i);
  assign mode_chg = (mode_n != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= TQ_LEVEL;
    else         mode_q <= mode_n;
  end

  tq_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (trig_i),
    .lvl_q_o (trig_q),
    .rise_o  (rise)
  );

  assign accept = rise && (mode_q == TQ_EDGE) && !mode_chg && !bo_busy;

  tq_backoff #(.BO_W(BO_W)) u_backoff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mode_chg),
    .load_i (accept),
    .val_i  (backoff_i),
    .busy_o (bo_busy)
  );

  tq_window #(.CNT_W(CNT_W)) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mode_chg),
    .load_i (accept),
    .len_i  (smp_cnt_i),
    .stb_i  (smp_stb_i),
    .open_o (win_open)
  );

  assign en_o = (mode_q == TQ_EDGE) ? win_open : trig_q;

  a_r2_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_n == TQ_LEVEL && mode_q == TQ_LEVEL) |=> (en_o == $past(trig_i)));

  a_r3_accept_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> en_o);

  a_r6_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bo_busy |-> !accept);

  a_r9_mode_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !win_open);

  a_r9_level_no_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TQ_LEVEL) |-> !win_open);
endmodule

// File: tb/tb_trig_qualifier.sv
module tb_trig_qualifier;
  localparam int CNT_W = 64;
  localparam int BO_W  = 31;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             trig_i;
  logic             smp_stb_i;
  logic             mode_i;
  logic [CNT_W-1:0] smp_cnt_i;
  logic [BO_W-1:0]  backoff_i;
  logic             en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  trig_qualifier #(.CNT_W(CNT_W), .BO_W(BO_W)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .smp_stb_i (smp_stb_i),
    .mode_i    (mode_i),
    .smp_cnt_i (smp_cnt_i),
    .backoff_i (backoff_i),
    .en_o      (en_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  // back to level mode with trigger low, then arm edge mode
  task automatic to_edge();
    mode_i = 1'b0; trig_i = 1'b0; smp_stb_i = 1'b0;
    nx(); nx();
    mode_i = 1'b1;
    nx();
  endtask

  task automatic win_run(input int n, input int s);
    int hi;
    to_edge();
    smp_cnt_i = CNT_W'(n); backoff_i = '0; trig_i = 1'b1;
    nx();                               // accepting edge
    smp_cnt_i = 64'd999;                // R8: ignored mid-window
    if (s == 2) trig_i = 1'b0;          // R3: falling trigger must not close
    hi = 0;
    for (int k = 1; k < 400; k++) begin
      if (!en_o) break;
      hi++;
      smp_stb_i = ((k % s) == 0);
      nx();
    end
    chk("R4", hi, n * s);
    smp_stb_i = 1'b0;
  endtask

  initial begin
    int hi;
    bit ok;
    logic [31:0] pat;
    rst_ni = 1'b0; trig_i = 1'b0; smp_stb_i = 1'b0; mode_i = 1'b0;
    smp_cnt_i = '0; backoff_i = '0;
    nx(); nx();
    chk("R1 en in reset", en_o, 0);
    rst_ni = 1'b1; trig_i = 1'b1;
    nx();
    chk("R1 level after reset", en_o, 1);
    trig_i = 1'b0;
    nx();

    // R2 level tracking, strobes and count toggled as noise
    pat = 32'hB4E1_6A3D;
    for (int i = 0; i < 32; i++) begin
      trig_i = pat[i]; smp_stb_i = i[0]; smp_cnt_i = CNT_W'(i % 3);
      nx();
      chk("R2", en_o, pat[i]);
    end

    // R4 window length sweep
    for (int n = 1; n <= 6; n++)
      for (int s = 1; s <= 3; s++)
        win_run(n, s);

    // R5 unlimited window, then R9 clear on mode change
    to_edge();
    smp_cnt_i = '0; trig_i = 1'b1;
    nx();
    trig_i = 1'b0; smp_stb_i = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      ok &= en_o;
      nx();
    end
    chk("R5", ok, 1);
    mode_i = 1'b0; nx();
    mode_i = 1'b1; nx(); nx();
    chk("R9 window cleared", en_o, 0);
    smp_stb_i = 1'b0;

    // R6 backoff vs edge distance
    for (int b = 0; b <= 4; b++) begin
      for (int d = 2; d <= 6; d++) begin
        to_edge();
        smp_cnt_i = 64'd1; backoff_i = BO_W'(b); trig_i = 1'b1;
        nx();                           // accept at edge 0
        trig_i = 1'b0; smp_stb_i = 1'b1; backoff_i = '0;  // R8 backoff latched
        nx();                           // edge 1 closes window
        smp_stb_i = 1'b0;
        repeat (d - 2) nx();
        trig_i = 1'b1;
        nx();                           // rise at edge d
        chk("R6", en_o, (d >= b + 1) ? 1 : 0);
      end
    end

    // R7 restart reloads from current count
    to_edge();
    smp_cnt_i = 64'd3; backoff_i = '0; trig_i = 1'b1;
    nx();                               // edge 0
    trig_i = 1'b0; smp_stb_i = 1'b1;
    nx();                               // edge 1
    smp_cnt_i = 64'd5; trig_i = 1'b1;
    nx();                               // edge 2 restart
    hi = 2;
    for (int i = 0; i < 50; i++) begin
      if (!en_o) break;
      hi++;
      nx();
    end
    chk("R7", hi, 7);
    smp_stb_i = 1'b0;

    // R9 rise together with mode change is dropped; R3 held high does nothing
    mode_i = 1'b0; trig_i = 1'b0; nx(); nx();
    smp_cnt_i = '0;
    mode_i = 1'b1; trig_i = 1'b1;
    nx();
    chk("R9 rise on change", en_o, 0);
    for (int i = 0; i < 3; i++) begin
      nx();
      chk("R3 held high", en_o, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule